// File: doc/BRIEF.md
# Input Change Interrupt and Wake

This block monitors a parallel input port and raises a change interrupt whenever a pin configured as an input no longer matches the value captured by the most recent software read of the port. The read defines the baseline, so software must read the port once before it enables the interrupt. Pins driven as outputs never take part in the comparison. Pin values pass through a synchroniser before they reach the comparator.

A change sets a sticky pending flag. Software clears the flag by writing zero to it. While the core sleeps, an unmasked mismatch raises a wake request at once, provided the change interrupt was enabled before the core went to sleep. The block then picks the resume path. With global interrupts disabled, the core continues at the next instruction. With global interrupts enabled, the core branches to the interrupt vector at address 008H.

Top module: `pinchg_wake`

## Requirements
- R1: While reset is held, and on the first cycle after it, the pending flag, the reference value and every request output are 0.
- R2: A pin value passes through two flops before comparison, so a change driven before clock edge k can first affect wake_req after edge k+1 and pend_flag after edge k+2.
- R3: A pulse on rd_strobe loads the synchronised pin values into the reference, and later comparisons use that reference.
- R4: Only pins whose pin_dir bit is 1 (input) are compared. A difference on a pin whose pin_dir bit is 0 (output) never sets the flag and never wakes the core.
- R5: pend_flag is set on the clock edge that follows any unmasked mismatch and then holds until pend_clr. When a set and a clear fall in the same cycle, the set wins.
- R6: irq_req is high exactly when pend_flag and chg_ie are both high.
- R7: wake_req is high, without a register delay, while asleep is high, an unmasked mismatch exists, and chg_ie was 1 on the last clock edge before sleep began. Changing chg_ie during sleep has no effect on wake_req.
- R8: vec_req is high when gie is 1 and either wake_req or irq_req is high. vec_addr always reads 0x008.
- R9: resume_req (continue at the next instruction) is high when wake_req is high and gie is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Raw port pin values |
| pin_dir | input | 8 | Per-pin direction: 1 = input, 0 = output |
| rd_strobe | input | 1 | Software port read; loads the reference |
| pend_clr | input | 1 | Software write of 0 to the pending flag |
| chg_ie | input | 1 | Change interrupt enable |
| gie | input | 1 | Global interrupt enable |
| asleep | input | 1 | Core is in sleep mode |
| pend_flag | output | 1 | Sticky change-pending flag |
| irq_req | output | 1 | Change interrupt request |
| wake_req | output | 1 | Wake request while asleep |
| resume_req | output | 1 | Wake without a branch, continue at the next instruction |
| vec_req | output | 1 | Branch to the interrupt vector |
| vec_addr | output | 12 | Interrupt vector address |

## Verification
The bench runs a cycle model alongside the design under seeded random pin, direction, read, clear, enable and sleep activity. This tests the masking, the reference reload and the sticky flag over many mixed combinations. Directed cases cover three situations. The first changes only pins set as outputs, which separates correct masking from a plain compare. The second reads and then clears, which shows whether the reference really reloads. The third enters sleep with the enable dropped after arming. It measures the two-edge synchroniser delay and shows which of gie's two branches the wake takes.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
   localparam int unsigned DEF_WIDTH  = 8;
   localparam int unsigned DEF_STAGES = 2;
   localparam int unsigned DEF_ADDR_W = 12;

   // Per-pin compare qualifier: a pin counts only when configured as input.
   function automatic logic pin_live(input logic dir_bit, input logic in_is_one);
      return in_is_one ? dir_bit : ~dir_bit;
   endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[i] <= '0;
               else        stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   assign q = stg_q[LAST];
endmodule

// File: rtl/pinchg_ref.sv
module pinchg_ref
   import pinchg_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          DIR_IN_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_s,
   input  logic [WIDTH-1:0] pin_dir,
   input  logic             rd_strobe,
   output logic [WIDTH-1:0] ref_q,
   output logic             mism_any
);
   logic [WIDTH-1:0] mism;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ref_q <= '0;
      else if (rd_strobe) ref_q <= pin_s;
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign mism[b] = pin_live(pin_dir[b], DIR_IN_HI) & (pin_s[b] ^ ref_q[b]);
      end
   endgenerate

   assign mism_any = |mism;
endmodule

// File: rtl/pinchg_pend.sv
module pinchg_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic mism_any,
   input  logic pend_clr,
   output logic pend_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_flag <= 1'b0;
      else if (mism_any) pend_flag <= 1'b1;
      else if (pend_clr) pend_flag <= 1'b0;
   end
endmodule

// File: rtl/pinchg_ctl.sv
module pinchg_ctl #(
   parameter int unsigned          ADDR_W   = 12,
   parameter logic [ADDR_W-1:0]    VEC_ADDR = 12'h008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mism_any,
   input  logic              pend_flag,
   input  logic              chg_ie,
   input  logic              gie,
   input  logic              asleep,
   output logic              armed_q,
   output logic              irq_req,
   output logic              wake_req,
   output logic              resume_req,
   output logic              vec_req,
   output logic [ADDR_W-1:0] vec_addr
);
   // Enable is frozen at the value it had when sleep began.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (!asleep) armed_q <= chg_ie;
   end

   assign irq_req    = pend_flag & chg_ie;
   assign wake_req   = asleep & armed_q & mism_any;
   assign resume_req = wake_req & ~gie;
   assign vec_req    = gie & (wake_req | irq_req);
   assign vec_addr   = VEC_ADDR;
endmodule

// File: rtl/pinchg_wake.sv
module pinchg_wake
   import pinchg_pkg::*;
#(
   parameter int unsigned             WIDTH     = DEF_WIDTH,
   parameter int unsigned             STAGES    = DEF_STAGES,
   parameter int unsigned             ADDR_W    = DEF_ADDR_W,
   parameter logic [DEF_ADDR_W-1:0]   VEC_ADDR  = 12'h008,
   parameter bit                      DIR_IN_HI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  pin_in,
   input  logic [WIDTH-1:0]  pin_dir,
   input  logic              rd_strobe,
   input  logic              pend_clr,
   input  logic              chg_ie,
   input  logic              gie,
   input  logic              asleep,
   output logic              pend_flag,
   output logic              irq_req,
   output logic              wake_req,
   output logic              resume_req,
   output logic              vec_req,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam logic [ADDR_W-1:0] VEC_FIT = ADDR_W'(VEC_ADDR);

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("pinchg_wake: WIDTH must be 1..64");
      end
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("pinchg_wake: STAGES must be 2..4");
      end
      if (ADDR_W < 4 || ADDR_W > DEF_ADDR_W) begin : g_bad_addr
         $error("pinchg_wake: ADDR_W out of range");
      end
   endgenerate

   logic [WIDTH-1:0] pin_s;
   logic [WIDTH-1:0] ref_q;
   logic             mism_any;
   logic             armed_q;

   pinchg_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   pinchg_ref #(.WIDTH(WIDTH), .DIR_IN_HI(DIR_IN_HI)) u_ref (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pin_dir(pin_dir),
      .rd_strobe(rd_strobe), .ref_q(ref_q), .mism_any(mism_any)
   );

   pinchg_pend u_pend (
      .clk(clk), .rst_n(rst_n), .mism_any(mism_any),
      .pend_clr(pend_clr), .pend_flag(pend_flag)
   );

   pinchg_ctl #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_FIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .mism_any(mism_any), .pend_flag(pend_flag),
      .chg_ie(chg_ie), .gie(gie), .asleep(asleep), .armed_q(armed_q),
      .irq_req(irq_req), .wake_req(wake_req), .resume_req(resume_req),
      .vec_req(vec_req), .vec_addr(vec_addr)
   );
endmodule

// File: rtl/pinchg_wake_chk.sv
module pinchg_wake_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_strobe,
   input logic             pend_clr,
   input logic             asleep,
   input logic             gie,
   input logic [WIDTH-1:0] pin_s,
   input logic [WIDTH-1:0] ref_q,
   input logic             mism_any,
   input logic             armed_q,
   input logic             pend_flag,
   input logic             wake_req,
   input logic             resume_req,
   input logic             vec_req
);
   assert_ref_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> ref_q == $past(pin_s));

   assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mism_any |=> pend_flag);

   assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flag && !pend_clr) |=> pend_flag);

   assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flag && pend_clr && !mism_any) |=> !pend_flag);

   assert_wake_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (asleep && armed_q));

   assert_arm_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> $stable(armed_q));

   assert_vec_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> gie);

   assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |-> (wake_req && !gie && !vec_req));
endmodule

bind pinchg_wake pinchg_wake_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .pend_clr(pend_clr),
   .asleep(asleep), .gie(gie), .pin_s(pin_s), .ref_q(ref_q),
   .mism_any(mism_any), .armed_q(armed_q), .pend_flag(pend_flag),
   .wake_req(wake_req), .resume_req(resume_req), .vec_req(vec_req)
);

// File: tb/pinchg_wake_bench.sv
`timescale 1ns/1ps
module pinchg_wake_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_dir = '1;
   logic         rd_strobe = 1'b0;
   logic         pend_clr = 1'b0;
   logic         chg_ie = 1'b0;
   logic         gie = 1'b0;
   logic         asleep = 1'b0;
   logic         pend_flag, irq_req, wake_req, resume_req, vec_req;
   logic [11:0]  vec_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit run_chk  = 1'b0;

   always #10 clk = ~clk;

   pinchg_wake u_pinchg_wake (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
      .rd_strobe(rd_strobe), .pend_clr(pend_clr), .chg_ie(chg_ie), .gie(gie),
      .asleep(asleep), .pend_flag(pend_flag), .irq_req(irq_req),
      .wake_req(wake_req), .resume_req(resume_req), .vec_req(vec_req),
      .vec_addr(vec_addr)
   );

   // Cycle model built from the requirements.
   logic [W-1:0] m_s1, m_s2, m_ref;
   logic         m_pend, m_armed;

   function automatic logic f_mism(input logic [W-1:0] s, input logic [W-1:0] r,
                                   input logic [W-1:0] d);
      return |((s ^ r) & d);
   endfunction

   function automatic logic f_wake(input logic slp, input logic arm, input logic mm);
      return slp & arm & mm;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_ref = '0; m_pend = 1'b0; m_armed = 1'b0;
      end else begin
         if (f_mism(m_s2, m_ref, pin_dir)) m_pend = 1'b1;
         else if (pend_clr)                m_pend = 1'b0;
         if (rd_strobe) m_ref = m_s2;
         if (!asleep)   m_armed = chg_ie;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
   end

   task automatic check(input logic act, input logic exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
      end
   endtask

   // Continuous comparison, half a cycle away from the active edge.
   always @(negedge clk) begin
      if (run_chk && rst_n) begin
         #5;
         begin
            logic e_wake, e_irq;
            e_wake = f_wake(asleep, m_armed, f_mism(m_s2, m_ref, pin_dir));
            e_irq  = m_pend & chg_ie;
            check(pend_flag,  m_pend,             "R5 pend_flag");
            check(irq_req,    e_irq,              "R6 irq_req");
            check(wake_req,   e_wake,             "R7 wake_req");
            check(vec_req,    gie & (e_wake | e_irq), "R8 vec_req");
            check(resume_req, e_wake & ~gie,      "R9 resume_req");
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      cyc(2);
      #5;
      check(pend_flag | irq_req | wake_req | vec_req | resume_req, 1'b0, "R1 reset outputs");
      @(negedge clk); rst_n = 1'b1;
      #5;
      check(pend_flag | irq_req | wake_req | vec_req | resume_req, 1'b0, "R1 after release");
      check(vec_addr == 12'h008, 1'b1, "R8 vec_addr");
      run_chk = 1'b1;

      // R4: only output pins change
      @(negedge clk); pin_dir = 8'h0F; pin_in = 8'hF0;
      cyc(5); #5;
      check(pend_flag, 1'b0, "R4 output pins masked");

      // R3/R5: input pin change, read, then clear
      @(negedge clk); pin_in = 8'hF1;
      cyc(3); #5;
      check(pend_flag, 1'b1, "R5 set after input change");
      @(negedge clk); rd_strobe = 1'b1; pend_clr = 1'b1;
      @(negedge clk); rd_strobe = 1'b0; #5;
      check(pend_flag, 1'b1, "R5 set wins over clear");
      @(negedge clk); pend_clr = 1'b0;
      cyc(3); #5;
      check(pend_flag, 1'b0, "R3 reference reloaded by read");

      // R2/R7/R9/R8: sleep wake path
      @(negedge clk); chg_ie = 1'b1; gie = 1'b0;
      @(negedge clk); asleep = 1'b1; chg_ie = 1'b0; pin_in = 8'hF3;
      @(negedge clk); #5;
      check(wake_req, 1'b0, "R2 one edge not enough");
      @(negedge clk); #5;
      check(wake_req,   1'b1, "R7 wake with enable frozen");
      check(resume_req, 1'b1, "R9 resume without gie");
      @(negedge clk); gie = 1'b1; #5;
      check(vec_req,    1'b1, "R8 branch with gie");
      check(resume_req, 1'b0, "R9 no resume with gie");
      @(negedge clk); asleep = 1'b0; rd_strobe = 1'b1; pend_clr = 1'b1;
      @(negedge clk); rd_strobe = 1'b0; pend_clr = 1'b0; pin_dir = 8'hFF;

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom_range(3) == 0)  pin_in  = W'($urandom);
         if ($urandom_range(19) == 0) pin_dir = W'($urandom);
         rd_strobe = ($urandom_range(7) == 0);
         pend_clr  = ($urandom_range(5) == 0);
         if ($urandom_range(9) == 0)  chg_ie = ~chg_ie;
         if ($urandom_range(7) == 0)  gie    = ~gie;
         if ($urandom_range(15) == 0) asleep = ~asleep;
      end
      @(negedge clk); #6;
      run_chk = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule